// File: doc/BRIEF.md
# IO Page-Table Address Translator

This block turns 32-bit addresses issued by DMA-capable devices into physical addresses. Software programs a control word and a table base through a small word-addressed register port. The control word enables translation and selects how large the device window is. The window is always anchored at the top of the 4 GB space and can be 16 MB to 2 GB in size.

Each translation request goes through a valid/ready handshake. When translation is on, the block first checks that the address lies inside the window. It then computes where the matching table entry sits in memory and fetches that one word through a simple request/acknowledge read port. Table entries are stored big-endian, so the block byte-swaps the fetched word before decoding it. The decoded entry is checked for validity and write permission. The block then returns either a physical address or a fault. When translation is off, the device address is returned unchanged and no memory read takes place. Only one translation is in flight at a time.

Top module: `iopt_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req` are 0. The control word (offset 0) reads as `{IMPL_ID, VER_ID, 24'h0}` and the table base (offset 1) reads as 0.
- R2: A write to offset 0 stores the full control word. Reading offset 0 returns bits [31:28] as `IMPL_ID` and bits [27:24] as `VER_ID`; bits [23:0] read back as written. A write to offset 1 stores the base, which reads back unchanged.
- R3: Writes to offsets 5 and 6 (flush strobes), and to any other unlisted offset, leave the control word and base unchanged. Reads of those offsets return 0.
- R4: With control bit 0 clear, a request returns `rsp_paddr` equal to `req_addr` with `rsp_fault` 0, and `mem_req` never rises.
- R5: With control bit 0 set, the range code in control bits [4:2] selects a window start of 2^32 − 2^(24+code). A request below that start returns `rsp_fault` 1 with `rsp_paddr` 0, and no memory read is made.
- R6: For an in-window request, `mem_addr` equals base·16 + 4·((`req_addr` − start) >> 12), taken modulo 2^32.
- R7: `mem_rdata` is taken as big-endian. The decoded entry is the byte-reversed word, so decoded bits [7:0] come from `mem_rdata[31:24]`.
- R8: For a decoded entry with bit 1 (valid) set and no permission fault, `rsp_paddr` = {1'b0, entry[26:8], `req_addr`[11:0]} and `rsp_fault` is 0. Decoded bits [31:27] are ignored.
- R9: A decoded entry with bit 1 clear yields `rsp_fault` 1 and `rsp_paddr` 0.
- R10: A write request (`req_write` 1) to a decoded entry with bit 2 (writable) clear yields a fault. A read request to the same entry does not.
- R11: `req_ready` is 0 from acceptance until the response handshake completes. While `rsp_valid` is 1 and `rsp_ready` is 0, the response holds steady.
- R12: `mem_req`, once raised, stays high with a stable `mem_addr` until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translation request accepted when high |
| req_addr | input | 32 | Device address |
| req_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation failed |
| mem_req | output | 1 | Table-entry read request |
| mem_addr | output | 32 | Table-entry byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Fetched table word, big-endian |

## Verification
The hardest cases to reach are the edges of the window. The first page at the window start and the last byte below it must land on opposite sides of the fault decision, and at the top byte of the space the entry index is largest. The bench sweeps all eight range codes and gives each a different base. At every code it aims requests at the start, at start minus one, at a middle page and at 0xFFFFFFFF. Each fetched word is derived from its own entry address with junk in the ignored upper bits. A wrong index, a wrong byte swap or a wrong field slice therefore each change the physical address that comes back.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

   typedef enum logic [1:0] {
      WALK_IDLE  = 2'd0,
      WALK_FETCH = 2'd1,
      WALK_RESP  = 2'd2
   } walk_state_t;

   function automatic logic [31:0] swap_bytes32(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

endpackage

// File: rtl/iopt_regs.sv
module iopt_regs
   import iopt_pkg::*;
#(
   parameter int          ADDR_W        = 32,
   parameter int          REG_AW        = 3,
   parameter int          RANGE_LSB     = 2,
   parameter int          RANGE_W       = 3,
   parameter int          MIN_WIN_SHIFT = 24,
   parameter int          BASE_SHIFT    = 4,
   parameter logic [3:0]  IMPL_ID       = 4'h4,
   parameter logic [3:0]  VER_ID        = 4'h1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] off,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [ADDR_W-1:0] rd_data,
   output logic              xlate_en,
   output logic [ADDR_W-1:0] win_start,
   output logic [ADDR_W-1:0] tbl_start
);
   localparam logic [REG_AW-1:0] OFF_CTRL = REG_AW'(0);
   localparam logic [REG_AW-1:0] OFF_BASE = REG_AW'(1);
   localparam int                ID_LSB   = ADDR_W - 8;

   function automatic logic [ADDR_W-1:0] start_of(input logic [RANGE_W-1:0] code);
      logic [ADDR_W:0] span;
      logic [ADDR_W:0] top;
      span = (ADDR_W+1)'(1) << (MIN_WIN_SHIFT + int'(code));
      top  = (ADDR_W+1)'(1) << ADDR_W;
      return ADDR_W'(top - span);
   endfunction

   logic [ADDR_W-1:0] ctrl_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] win_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         base_q <= '0;
         win_q  <= start_of('0);
      end else if (wr_en) begin
         case (off)
            OFF_CTRL: begin
               ctrl_q <= wr_data;
               win_q  <= start_of(wr_data[RANGE_LSB +: RANGE_W]);
            end
            OFF_BASE: base_q <= wr_data;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (off)
         OFF_CTRL: rd_data = {IMPL_ID, VER_ID, ctrl_q[ID_LSB-1:0]};
         OFF_BASE: rd_data = base_q;
         default:  rd_data = '0;
      endcase
   end

   assign xlate_en  = ctrl_q[0];
   assign win_start = win_q;
   assign tbl_start = base_q << BASE_SHIFT;

endmodule

// File: rtl/iopt_entry_dec.sv
module iopt_entry_dec
   import iopt_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PPN_LSB    = 8,
   parameter int PPN_W      = 19,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [ADDR_W-1:0] raw,
   output logic [PPN_W-1:0]  ppn,
   output logic              ent_valid,
   output logic              ent_wr_ok
);
   logic [ADDR_W-1:0] word;

   generate
      if (BIG_ENDIAN) begin : g_swap
         assign word = swap_bytes32(raw);
      end else begin : g_native
         assign word = raw;
      end
   endgenerate

   assign ppn       = word[PPN_LSB +: PPN_W];
   assign ent_valid = word[1];
   assign ent_wr_ok = word[2];

endmodule

// File: rtl/iopt_walk.sv
module iopt_walk
   import iopt_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int PPN_W      = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xlate_en,
   input  logic [ADDR_W-1:0] win_start,
   input  logic [ADDR_W-1:0] tbl_start,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic              rsp_fault,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [PPN_W-1:0]  ent_ppn,
   input  logic              ent_valid,
   input  logic              ent_wr_ok
);
   localparam int HI_PAD = ADDR_W - PPN_W - PAGE_SHIFT;

   walk_state_t            state_q;
   logic [ADDR_W-1:0]      ent_addr_q;
   logic [PAGE_SHIFT-1:0]  page_off_q;
   logic                   is_wr_q;
   logic [ADDR_W-1:0]      paddr_q;
   logic                   fault_q;
   logic [ADDR_W-1:0]      win_off;
   logic [ADDR_W-1:0]      ent_addr_d;
   logic                   below_win;

   assign win_off    = req_addr - win_start;
   assign ent_addr_d = tbl_start + ((win_off >> PAGE_SHIFT) << 2);
   assign below_win  = req_addr < win_start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= WALK_IDLE;
         ent_addr_q <= '0;
         page_off_q <= '0;
         is_wr_q    <= 1'b0;
         paddr_q    <= '0;
         fault_q    <= 1'b0;
      end else begin
         case (state_q)
            WALK_IDLE: if (req_valid) begin
               page_off_q <= req_addr[PAGE_SHIFT-1:0];
               is_wr_q    <= req_write;
               ent_addr_q <= ent_addr_d;
               if (!xlate_en) begin
                  paddr_q <= req_addr;
                  fault_q <= 1'b0;
                  state_q <= WALK_RESP;
               end else if (below_win) begin
                  paddr_q <= '0;
                  fault_q <= 1'b1;
                  state_q <= WALK_RESP;
               end else begin
                  state_q <= WALK_FETCH;
               end
            end
            WALK_FETCH: if (mem_ack) begin
               if (!ent_valid || (is_wr_q && !ent_wr_ok)) begin
                  paddr_q <= '0;
                  fault_q <= 1'b1;
               end else begin
                  paddr_q <= {{HI_PAD{1'b0}}, ent_ppn, page_off_q};
                  fault_q <= 1'b0;
               end
               state_q <= WALK_RESP;
            end
            WALK_RESP: if (rsp_ready) state_q <= WALK_IDLE;
            default: state_q <= WALK_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == WALK_IDLE);
   assign mem_req   = (state_q == WALK_FETCH);
   assign mem_addr  = ent_addr_q;
   assign rsp_valid = (state_q == WALK_RESP);
   assign rsp_paddr = paddr_q;
   assign rsp_fault = fault_q;

endmodule

// File: rtl/iopt_xlate.sv
module iopt_xlate
   import iopt_pkg::*;
#(
   parameter int         ADDR_W        = 32,
   parameter int         REG_AW        = 3,
   parameter int         PAGE_SHIFT    = 12,
   parameter int         RANGE_LSB     = 2,
   parameter int         RANGE_W       = 3,
   parameter int         MIN_WIN_SHIFT = 24,
   parameter int         BASE_SHIFT    = 4,
   parameter int         PPN_LSB       = 8,
   parameter bit         BIG_ENDIAN    = 1'b1,
   parameter logic [3:0] IMPL_ID       = 4'h4,
   parameter logic [3:0] VER_ID        = 4'h1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic              rsp_fault,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rdata
);
   localparam int PPN_W = ADDR_W - 1 - PAGE_SHIFT;

   generate
      if (ADDR_W != 32) begin : g_bad_width
         $error("iopt_xlate: entry byte order needs ADDR_W of 32");
      end
      if (MIN_WIN_SHIFT + (1 << RANGE_W) - 1 > ADDR_W - 1) begin : g_bad_range
         $error("iopt_xlate: largest window exceeds address space");
      end
      if (PPN_LSB + PPN_W > ADDR_W) begin : g_bad_ppn
         $error("iopt_xlate: page field does not fit in an entry");
      end
      if (REG_AW < 3) begin : g_bad_regaw
         $error("iopt_xlate: register offset too narrow");
      end
   endgenerate

   logic              xlate_en;
   logic [ADDR_W-1:0] win_start;
   logic [ADDR_W-1:0] tbl_start;
   logic [PPN_W-1:0]  ent_ppn;
   logic              ent_valid;
   logic              ent_wr_ok;

   iopt_regs #(
      .ADDR_W(ADDR_W), .REG_AW(REG_AW), .RANGE_LSB(RANGE_LSB),
      .RANGE_W(RANGE_W), .MIN_WIN_SHIFT(MIN_WIN_SHIFT),
      .BASE_SHIFT(BASE_SHIFT), .IMPL_ID(IMPL_ID), .VER_ID(VER_ID)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .off(reg_addr),
      .wr_data(reg_wdata), .rd_data(reg_rdata), .xlate_en(xlate_en),
      .win_start(win_start), .tbl_start(tbl_start)
   );

   iopt_entry_dec #(
      .ADDR_W(ADDR_W), .PPN_LSB(PPN_LSB), .PPN_W(PPN_W), .BIG_ENDIAN(BIG_ENDIAN)
   ) u_dec (
      .raw(mem_rdata), .ppn(ent_ppn), .ent_valid(ent_valid), .ent_wr_ok(ent_wr_ok)
   );

   iopt_walk #(
      .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PPN_W(PPN_W)
   ) u_walk (
      .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .win_start(win_start),
      .tbl_start(tbl_start), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .ent_ppn(ent_ppn), .ent_valid(ent_valid), .ent_wr_ok(ent_wr_ok)
   );

endmodule

// File: rtl/iopt_xlate_chk.sv
module iopt_xlate_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_ready,
   input logic        rsp_valid,
   input logic        rsp_ready,
   input logic [31:0] rsp_paddr,
   input logic        rsp_fault,
   input logic        mem_req,
   input logic [31:0] mem_addr,
   input logic        mem_ack
);
   assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

   assert_busy_while_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   assert_accept_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

   assert_fault_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_paddr == 32'h0);

   assert_fetch_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready && !rsp_valid);
endmodule

bind iopt_xlate iopt_xlate_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
   .rsp_fault(rsp_fault), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/iopt_xlate_bench.sv
module iopt_xlate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [31:0] rsp_paddr;
   logic        rsp_fault;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   int n_chk = 0;
   int n_fail = 0;
   int mem_cnt = 0;
   logic [31:0] seen_addr = '0;
   logic [7:0]  ent_flags = 8'h86;

   always #4 clk = ~clk;

   iopt_xlate u_iopt_xlate (.*);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [18:0] page_of(input logic [31:0] a);
      return a[20:2] ^ 19'h2A5C3;
   endfunction

   function automatic logic [31:0] bswap(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   // memory responder: acks after the request has been held two cycles
   initial begin
      int wait_n;
      logic [31:0] first_addr;
      wait_n = 0;
      first_addr = '0;
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
         end else if (mem_req) begin
            if (wait_n == 0) first_addr = mem_addr;
            if (wait_n < 2) begin
               wait_n++;
            end else begin
               wait_n = 0;
               chk(mem_addr == first_addr, "R12 mem_addr stable", mem_addr, first_addr);
               seen_addr = mem_addr;
               mem_rdata = bswap({5'h15, page_of(mem_addr), ent_flags});
               mem_ack = 1'b1;
               mem_cnt++;
            end
         end
      end
   end

   task automatic reg_wr(input logic [2:0] off, input logic [31:0] val);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = off; reg_wdata = val;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [2:0] off, output logic [31:0] val);
      @(negedge clk);
      reg_addr = off;
      #1;
      val = reg_rdata;
   endtask

   task automatic xlate(input logic [31:0] a, input logic wr,
                        output logic [31:0] pa, output logic flt, output int fetches);
      int start_cnt;
      logic [31:0] held;
      start_cnt = mem_cnt;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R11 busy after accept", 32'(req_ready), 32'h0);
      while (!rsp_valid) @(negedge clk);
      held = rsp_paddr;
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == held && !req_ready, "R11 stall hold", rsp_paddr, held);
      rsp_ready = 1'b1;
      pa = rsp_paddr; flt = rsp_fault;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(req_ready && !rsp_valid, "R11 idle after handshake", 32'(req_ready), 32'h1);
      fetches = mem_cnt - start_cnt;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] rv, pa, st, base, a, ea;
      logic        flt;
      int          nf;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready && !rsp_valid && !mem_req, "R1 handshake idle", {29'h0, req_ready, rsp_valid, mem_req}, 32'h4);
      reg_rd(3'd0, rv); chk(rv == 32'h4100_0000, "R1 ctrl reset", rv, 32'h4100_0000);
      reg_rd(3'd1, rv); chk(rv == 32'h0, "R1 base reset", rv, 32'h0);
      // R2 register write/readback
      reg_wr(3'd0, 32'h1234_5678);
      reg_rd(3'd0, rv); chk(rv == 32'h4134_5678, "R2 ctrl readback", rv, 32'h4134_5678);
      reg_wr(3'd1, 32'h00AB_CDE0);
      reg_rd(3'd1, rv); chk(rv == 32'h00AB_CDE0, "R2 base readback", rv, 32'h00AB_CDE0);
      // R3 flush strobes and other offsets are inert
      for (int o = 2; o < 8; o++) begin
         reg_wr(3'(o), 32'hFFFF_FFFF);
         reg_rd(3'(o), rv); chk(rv == 32'h0, "R3 unlisted reads zero", rv, 32'h0);
      end
      reg_rd(3'd0, rv); chk(rv == 32'h4134_5678, "R3 ctrl untouched", rv, 32'h4134_5678);
      reg_rd(3'd1, rv); chk(rv == 32'h00AB_CDE0, "R3 base untouched", rv, 32'h00AB_CDE0);
      // R4 pass-through when disabled
      reg_wr(3'd0, 32'h0000_001C);
      foreach (rv[i]) ; // no-op keeps rv in scope
      xlate(32'h0000_1234, 1'b1, pa, flt, nf);
      chk(pa == 32'h0000_1234 && !flt && nf == 0, "R4 low passthrough", pa, 32'h0000_1234);
      xlate(32'hFF00_0ABC, 1'b0, pa, flt, nf);
      chk(pa == 32'hFF00_0ABC && !flt && nf == 0, "R4 high passthrough", pa, 32'hFF00_0ABC);
      // R5..R8 sweep over every range code
      ent_flags = 8'h86;
      for (int code = 0; code < 8; code++) begin
         st = 32'(64'h1_0000_0000 - (64'h1 << (24 + code)));
         base = 32'h1010_0000 + 32'(code * 32'h111);
         reg_wr(3'd1, base);
         reg_wr(3'd0, 32'(code << 2) | 32'h1);
         a = st - 32'h1;
         xlate(a, 1'b0, pa, flt, nf);
         chk(flt && pa == 32'h0 && nf == 0, "R5 below window faults", {pa[30:0], flt}, 32'h1);
         for (int k = 0; k < 3; k++) begin
            a = (k == 0) ? st + 32'h0000_0ABC :
                (k == 1) ? 32'hFFFF_FFFF :
                           st + ((32'hFFFF_FFFF - st) >> 1);
            ea = (base << 4) + (((a - st) >> 12) << 2);
            xlate(a, 1'b0, pa, flt, nf);
            chk(nf == 1 && seen_addr == ea, "R6 entry address", seen_addr, ea);
            chk(!flt && pa == {1'b0, page_of(ea), a[11:0]}, "R7 R8 physical address",
                pa, {1'b0, page_of(ea), a[11:0]});
         end
      end
      // permission and validity, code 7 window
      a = 32'h9234_5678;
      ent_flags = 8'h84;
      xlate(a, 1'b0, pa, flt, nf);
      chk(flt && pa == 32'h0 && nf == 1, "R9 invalid entry faults", {pa[30:0], flt}, 32'h1);
      ent_flags = 8'h82;
      xlate(a, 1'b1, pa, flt, nf);
      chk(flt && pa == 32'h0, "R10 write to read-only faults", {pa[30:0], flt}, 32'h1);
      xlate(a, 1'b0, pa, flt, nf);
      chk(!flt && pa[11:0] == 12'h678, "R10 read of read-only ok", pa, {20'h0, 12'h678});
      ent_flags = 8'h86;
      xlate(a, 1'b1, pa, flt, nf);
      chk(!flt && pa[11:0] == 12'h678, "R10 write to writable ok", pa, {20'h0, 12'h678});
      // R7 byte order: flags only in low byte of decoded entry
      ent_flags = 8'h02;
      xlate(a, 1'b0, pa, flt, nf);
      chk(!flt, "R7 low byte holds flags", {31'h0, flt}, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule